// File: doc/BRIEF.md
# Two-Phase Scan Chain Sequencer

This block is the host side of a latch-based serial configuration chain. It takes a parallel word as wide as the chain and one of two commands. From them it produces the slow pin-level waveforms that a master/slave latch chain needs. Those are a serial data line, two separately pulsed latch clocks that are never high together, a strobe that copies the chain into the chip's shadow latches, and a select that makes the chain capture the chip's internal view instead of shifting.

A write shifts the word into the chain and then pulses the shadow strobe once. A read first captures the chip's view with one clock pair while the select is high, and then shifts that view out. Both commands collect the bits that leave the chain, so every transaction returns a parallel read word. Bit 0 leaves first. Every pin edge is held off from the previous pin edge by a programmable number of system clocks. This keeps the waveform slow and ordered whatever the board delays are.

Top module: `twophase_scan_ctrl`

## Requirements
- R1: After reset, and whenever `busy_o` is low, all five scan pins (`scan_din_o`, `scan_phi_o`, `scan_phib_o`, `scan_shadow_o`, `scan_capture_o`) are low.
- R2: `scan_phi_o` and `scan_phib_o` are never high in the same cycle. In every step the phi pulse completes before the phi_b pulse begins.
- R3: `scan_din_o` is set before the phi pulse of its step and does not change while either latch clock is high.
- R4: A rotate is exactly CHAIN_LEN phi/phi_b pulse pairs. Bit k of the write word is driven in step k (bit 0 first), so a write gives CHAIN_LEN pairs and a read gives CHAIN_LEN+1.
- R5: `scan_dout_i` is sampled once per step, just before that step's phi pulse. Each sample enters the top of the read word, so at `done_o` bit k of `rd_word_o` is the bit that sat at chain position k before the rotate. After a write, this is the previously shifted-in word.
- R6: A write ends with exactly one high-then-low pulse on `scan_shadow_o`, after the last shift pair. The strobe is low whenever a latch clock or the capture select is high.
- R7: A read raises `scan_capture_o`, applies one phi pulse and then one phi_b pulse, lowers it, and only then starts the rotate. `rd_word_o` returns the captured chip view, and `scan_capture_o` is pulsed exactly once.
- R8: Any two changes on the scan pins are at least STEP_CLKS system clocks apart, including across the gap between two transactions.
- R9: `start_i` is taken only in a cycle with `busy_o` low. `done_o` is a single-cycle pulse at the end of each transaction. A `start_i` while busy is ignored and does not alter the transaction in flight.
- R10: A read leaves the shadow latches unchanged (no `scan_shadow_o` pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command request, taken when busy_o is low |
| cmd_read_i | input | 1 | 1 = read (capture then rotate), 0 = write (rotate then shadow strobe) |
| wr_word_i | input | CHAIN_LEN | Word shifted into the chain, bit 0 first |
| busy_o | output | 1 | High while a transaction or the closing spacing interval runs |
| done_o | output | 1 | One-cycle pulse when rd_word_o is valid |
| rd_word_o | output | CHAIN_LEN | Bits shifted out of the chain, aligned to chain position |
| scan_din_o | output | 1 | Serial data toward the chain |
| scan_phi_o | output | 1 | Master latch clock pulse |
| scan_phib_o | output | 1 | Slave latch clock pulse |
| scan_shadow_o | output | 1 | Strobe copying the chain into the shadow latches |
| scan_capture_o | output | 1 | Select making the chain load chip data |
| scan_dout_i | input | 1 | Serial data from the last chain stage |

## Verification
The assertions assume that `scan_dout_i` comes from a latch chain whose stages change only while a latch clock is high, so the sampled bit is settled one step after the phi_b pulse. They also assume that `start_i` is driven only from registered logic. The bench keeps to this with a chain model whose master, slave and shadow stages update only on the edges of the pins the block drives. The chip-side status word feeding the capture path changes only while the block is idle. Extra `start_i` pulses are sent only in the middle of a transaction, where the design must ignore them.

// File: rtl/twophase_scan_pkg.sv
package twophase_scan_pkg;

    // Sequencer steps; every non-idle step lasts STEP_CLKS system clocks.
    typedef enum logic [3:0] {
        PH_IDLE       = 4'd0,
        PH_CAP_ARM    = 4'd1,
        PH_CAP_PHI_HI = 4'd2,
        PH_CAP_PHI_LO = 4'd3,
        PH_CAP_PHB_HI = 4'd4,
        PH_CAP_PHB_LO = 4'd5,
        PH_CAP_DISARM = 4'd6,
        PH_SET_BIT    = 4'd7,
        PH_PHI_HI     = 4'd8,
        PH_PHI_LO     = 4'd9,
        PH_PHB_HI     = 4'd10,
        PH_PHB_LO     = 4'd11,
        PH_COMMIT_HI  = 4'd12,
        PH_COMMIT_LO  = 4'd13
    } phase_e;

    // Pin levels that depend only on the sequencer step.
    typedef struct packed {
        logic capture;
        logic shadow;
        logic phib;
        logic phi;
    } pins_t;

endpackage

// File: rtl/twophase_scan_timer.sv
module twophase_scan_timer #(
    parameter int STEP_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int TW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(STEP_CLKS - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/twophase_scan_bitcnt.sv
module twophase_scan_bitcnt #(
    parameter int CHAIN_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/twophase_scan_pins.sv
module twophase_scan_pins
    import twophase_scan_pkg::*;
(
    input  phase_e phase_i,
    output pins_t  pins_o
);
    always_comb begin
        pins_o = '0;
        unique case (phase_i)
            PH_CAP_ARM,
            PH_CAP_PHI_LO,
            PH_CAP_PHB_LO: pins_o.capture = 1'b1;
            PH_CAP_PHI_HI: begin
                pins_o.capture = 1'b1;
                pins_o.phi     = 1'b1;
            end
            PH_CAP_PHB_HI: begin
                pins_o.capture = 1'b1;
                pins_o.phib    = 1'b1;
            end
            PH_PHI_HI:     pins_o.phi    = 1'b1;
            PH_PHB_HI:     pins_o.phib   = 1'b1;
            PH_COMMIT_HI:  pins_o.shadow = 1'b1;
            default:       pins_o = '0;
        endcase
    end
endmodule

// File: rtl/twophase_scan_ctrl.sv
module twophase_scan_ctrl
    import twophase_scan_pkg::*;
#(
    parameter int CHAIN_LEN = 12,
    parameter int STEP_CLKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 cmd_read_i,
    input  logic [CHAIN_LEN-1:0] wr_word_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [CHAIN_LEN-1:0] rd_word_o,
    output logic                 scan_din_o,
    output logic                 scan_phi_o,
    output logic                 scan_phib_o,
    output logic                 scan_shadow_o,
    output logic                 scan_capture_o,
    input  logic                 scan_dout_i
);
    localparam int N = CHAIN_LEN;

    typedef struct packed {
        phase_e       phase;
        logic         is_read;
        logic [N-1:0] wr_sh;
        logic [N-1:0] rd;
        logic         din;
        pins_t        pins;
        logic         done;
    } regs_t;

    regs_t  r_d, r_q;
    logic   step_expired;
    logic   bit_last;
    logic   accept;
    logic   advance;
    logic   bit_step;
    pins_t  pins_next;
    logic [N-1:0] wr_next;
    logic [N:0]   rd_join;

    twophase_scan_timer #(.STEP_CLKS(STEP_CLKS)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept || advance),
        .expired_o (step_expired)
    );

    twophase_scan_bitcnt #(.CHAIN_LEN(CHAIN_LEN)) bitcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (bit_step),
        .last_o  (bit_last)
    );

    twophase_scan_pins pins_i (
        .phase_i (r_d.phase),
        .pins_o  (pins_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept   = 1'b0;
        advance  = 1'b0;
        bit_step = 1'b0;
        wr_next  = r_q.wr_sh >> 1;
        rd_join  = {scan_dout_i, r_q.rd};

        if (r_q.phase == PH_IDLE) begin
            // The idle step also lasts one spacing interval before a new start.
            if (start_i && step_expired) begin
                accept    = 1'b1;
                r_d.is_read = cmd_read_i;
                r_d.wr_sh = wr_word_i;
                if (cmd_read_i) begin
                    r_d.phase = PH_CAP_ARM;
                end else begin
                    r_d.phase = PH_SET_BIT;
                    r_d.din   = wr_word_i[0];
                end
            end
        end else if (step_expired) begin
            advance = 1'b1;
            unique case (r_q.phase)
                PH_CAP_ARM:    r_d.phase = PH_CAP_PHI_HI;
                PH_CAP_PHI_HI: r_d.phase = PH_CAP_PHI_LO;
                PH_CAP_PHI_LO: r_d.phase = PH_CAP_PHB_HI;
                PH_CAP_PHB_HI: r_d.phase = PH_CAP_PHB_LO;
                PH_CAP_PHB_LO: r_d.phase = PH_CAP_DISARM;
                PH_CAP_DISARM: begin
                    r_d.phase = PH_SET_BIT;
                    r_d.din   = r_q.wr_sh[0];
                end
                PH_SET_BIT: begin
                    // Slave latch is settled here: take the outgoing bit.
                    r_d.rd    = rd_join[N:1];
                    r_d.phase = PH_PHI_HI;
                end
                PH_PHI_HI:     r_d.phase = PH_PHI_LO;
                PH_PHI_LO:     r_d.phase = PH_PHB_HI;
                PH_PHB_HI:     r_d.phase = PH_PHB_LO;
                PH_PHB_LO: begin
                    bit_step = 1'b1;
                    if (!bit_last) begin
                        r_d.wr_sh = wr_next;
                        r_d.din   = wr_next[0];
                        r_d.phase = PH_SET_BIT;
                    end else if (r_q.is_read) begin
                        r_d.phase = PH_IDLE;
                        r_d.din   = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.phase = PH_COMMIT_HI;
                    end
                end
                PH_COMMIT_HI:  r_d.phase = PH_COMMIT_LO;
                PH_COMMIT_LO: begin
                    r_d.phase = PH_IDLE;
                    r_d.din   = 1'b0;
                    r_d.done  = 1'b1;
                end
                default: begin
                    r_d.phase = PH_IDLE;
                    r_d.din   = 1'b0;
                end
            endcase
        end

        r_d.pins = pins_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o         = (r_q.phase != PH_IDLE) || !step_expired;
    assign done_o         = r_q.done;
    assign rd_word_o      = r_q.rd;
    assign scan_din_o     = r_q.din;
    assign scan_phi_o     = r_q.pins.phi;
    assign scan_phib_o    = r_q.pins.phib;
    assign scan_shadow_o  = r_q.pins.shadow;
    assign scan_capture_o = r_q.pins.capture;
endmodule

// File: rtl/twophase_scan_chk.sv
module twophase_scan_chk #(
    parameter int STEP_CLKS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic scan_din_o,
    input logic scan_phi_o,
    input logic scan_phib_o,
    input logic scan_shadow_o,
    input logic scan_capture_o
);
    localparam int GW = $clog2(STEP_CLKS + 1) + 1;

    logic [4:0]    pins_now, pins_prev_q;
    logic [GW-1:0] gap_q;
    logic          armed_q;
    logic          chg;

    assign pins_now = {scan_din_o, scan_phi_o, scan_phib_o, scan_shadow_o, scan_capture_o};
    assign chg      = (pins_now != pins_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_prev_q <= '0;
            gap_q       <= '0;
            armed_q     <= 1'b0;
        end else begin
            pins_prev_q <= pins_now;
            if (chg) begin
                gap_q   <= GW'(1);
                armed_q <= 1'b1;
            end else if (gap_q < GW'(STEP_CLKS)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1
    pins_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pins_now == 5'b0));

    // R2
    no_clock_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_phi_o && scan_phib_o));

    // R3
    din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_phi_o || scan_phib_o) |-> $stable(scan_din_o));

    // R6
    shadow_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_shadow_o |-> !(scan_phi_o || scan_phib_o || scan_capture_o));

    // R7
    capture_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_capture_o) |-> !(scan_phi_o || scan_phib_o));

    // R8
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && armed_q) |-> (gap_q >= GW'(STEP_CLKS)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    accept_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && !done_o) |-> $past(start_i));
endmodule

bind twophase_scan_ctrl twophase_scan_chk #(.STEP_CLKS(STEP_CLKS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .scan_din_o     (scan_din_o),
    .scan_phi_o     (scan_phi_o),
    .scan_phib_o    (scan_phib_o),
    .scan_shadow_o  (scan_shadow_o),
    .scan_capture_o (scan_capture_o)
);

// File: tb/twophase_scan_ctrl_tb_top.sv
module twophase_scan_ctrl_tb_top;
    localparam int N    = 12;
    localparam int STEP = 2;
    localparam int H    = N / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_read = 1'b0;
    logic [N-1:0] wr_word = '0;
    logic busy, done;
    logic [N-1:0] rd_word;
    logic din, phi, phib, shadow_stb, capture;
    logic dout;

    always #2 clk = ~clk;

    twophase_scan_ctrl #(.CHAIN_LEN(N), .STEP_CLKS(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_read_i(cmd_read),
        .wr_word_i(wr_word), .busy_o(busy), .done_o(done), .rd_word_o(rd_word),
        .scan_din_o(din), .scan_phi_o(phi), .scan_phib_o(phib),
        .scan_shadow_o(shadow_stb), .scan_capture_o(capture), .scan_dout_i(dout)
    );

    // Behavioural latch chain: stages move only on the pins' rising edges.
    logic [N-1:0] master_q = '0;
    logic [N-1:0] slave_q  = '0;
    logic [N-1:0] shadow_q = '0;
    logic [N-1:0] status   = '0;
    logic [N-1:0] chip_view;
    assign chip_view = {status[N-1:H], shadow_q[H-1:0]};
    assign dout = slave_q[0];

    always @(posedge phi)        master_q <= capture ? chip_view : {din, slave_q[N-1:1]};
    always @(posedge phib)       slave_q  <= master_q;
    always @(posedge shadow_stb) shadow_q <= slave_q;

    typedef struct {
        logic [N-1:0] rd;
        logic [N-1:0] shadow;
        int           phi_n;
        int           shadow_n;
        int           capture_n;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: edge counting, spacing, scoreboard compare.
    logic [4:0] pv = '0;
    int gap = 0;
    bit armed = 0;
    int phi_r = 0, phib_r = 0, shd_r = 0, cap_r = 0;
    int overlap = 0, spacing_bad = 0, din_bad = 0, order_bad = 0;
    bit phi_seen = 0;
    bit done_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic [4:0] cv = {din, phi, phib, shadow_stb, capture};
            if (cv != pv) begin
                if (armed && gap < STEP) spacing_bad++;
                gap = 1;
                armed = 1;
            end else begin
                gap++;
            end
            if (phi && !pv[3]) begin phi_r++; phi_seen = 1; end
            if (phib && !pv[2]) begin
                phib_r++;
                if (!phi_seen) order_bad++;
                phi_seen = 0;
            end
            if (shadow_stb && !pv[1]) shd_r++;
            if (capture && !pv[0]) cap_r++;
            if (phi && phib) overlap++;
            if ((pv[3] || pv[2]) && (phi || phib) && din != pv[4]) din_bad++;
            pv = cv;

            if (done_prev) check(!done, "R9", "done width", done, 0);
            done_prev = done;
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected done", 1, 0);
                end else begin
                    automatic exp_t e = exp_q.pop_front();
                    check(rd_word == e.rd, "R5", "read word", rd_word, e.rd);
                    check(shadow_q == e.shadow, "R10", "shadow latches", shadow_q, e.shadow);
                    check(phi_r == e.phi_n, "R4", "phi pulses", phi_r, e.phi_n);
                    check(phib_r == e.phi_n, "R4", "phi_b pulses", phib_r, e.phi_n);
                    check(shd_r == e.shadow_n, "R6", "shadow strobes", shd_r, e.shadow_n);
                    check(cap_r == e.capture_n, "R7", "capture pulses", cap_r, e.capture_n);
                    check(overlap == 0 && order_bad == 0, "R2", "overlap/order", overlap + order_bad, 0);
                    check(din_bad == 0, "R3", "din moved under clock", din_bad, 0);
                    check(spacing_bad == 0, "R8", "edge spacing", spacing_bad, 0);
                end
                phi_r = 0; phib_r = 0; shd_r = 0; cap_r = 0;
                overlap = 0; spacing_bad = 0; din_bad = 0; order_bad = 0;
            end
        end
    end

    logic [N-1:0] chain_exp  = '0;
    logic [N-1:0] shadow_exp = '0;

    // Driver: pushes the expected outcome, then issues the command.
    task automatic run_txn(input bit is_read, input logic [N-1:0] word, input bit poke);
        exp_t e;
        e.rd        = is_read ? {status[N-1:H], shadow_exp[H-1:0]} : chain_exp;
        e.shadow    = is_read ? shadow_exp : word;
        e.phi_n     = is_read ? N + 1 : N;
        e.shadow_n  = is_read ? 0 : 1;
        e.capture_n = is_read ? 1 : 0;
        exp_q.push_back(e);
        chain_exp = word;
        if (!is_read) shadow_exp = word;
        while (busy) @(negedge clk);
        start = 1'b1; cmd_read = is_read; wr_word = word;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1; cmd_read = !is_read; wr_word = ~word;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({din, phi, phib, shadow_stb, capture} == 5'b0, "R1", "pins after reset",
              {din, phi, phib, shadow_stb, capture}, 0);
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);

        run_txn(0, 12'hA5C, 0);           // R4 R5 R6: first write returns zeros
        run_txn(0, 12'h3F1, 0);           // R5: returns previous word
        status = 12'hB40;
        run_txn(1, 12'h0F0, 0);           // R7 R10: capture view
        run_txn(0, 12'h801, 1);           // R9: start ignored while busy
        status = 12'h2C0;
        run_txn(1, 12'h555, 1);           // R9 R7
        run_txn(0, 12'hFFF, 0);
        run_txn(0, 12'h001, 0);
        status = 12'hFC0;
        run_txn(1, 12'hAAA, 0);
        run_txn(0, 12'h000, 0);           // R5: reads back AAA

        repeat (4) @(negedge clk);
        check(!busy, "R1", "idle at end", busy, 0);
        check({din, phi, phib, shadow_stb, capture} == 5'b0, "R1", "pins at end",
              {din, phi, phib, shadow_stb, capture}, 0);
        check(exp_q.size() == 0, "R9", "pending transactions", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule